// File: doc/BRIEF.md
# Lane-Parallel Carry-Less Multiplier

This block multiplies polynomials over GF(2) on several independent 128-bit lanes in parallel. Each lane carries two 128-bit operands. A shared 8-bit control byte picks one 64-bit half of each operand. The two halves are multiplied without carries, so partial products combine by XOR. The full 128-bit product is written back into the same lane. The lane count is a parameter: four lanes give a 512-bit vector and two lanes give a 256-bit vector.

Requests enter through a valid/ready handshake that carries both vectors and the control byte. The results of all lanes of one request leave together after a fixed, parameterised number of register stages. When the consumer withholds ready, the pipeline holds its contents and applies back-pressure to the input. Field reduction is left to downstream logic.

Top module: `gf2_lane_mul`

## Requirements
- R1: For each lane, the product equals the carry-less product of the two selected 64-bit halves: bit k is the XOR over i of a[i] AND b[k-i].
- R2: Control bit 0 picks the half of the first operand (0 = bits 63:0 of the lane, 1 = bits 127:64). Control bit 4 picks the half of the second operand in the same way.
- R3: Control bits 1, 2, 3, 5, 6 and 7 have no effect on the result.
- R4: One control byte applies the same half selection to every lane. Lane i of the result depends only on lane i of both operands. Lane i occupies bits 128*i+127 down to 128*i.
- R5: Bit 127 of every lane result is always zero.
- R6: With the output ready held high, a request accepted at a clock edge appears with out_valid high exactly LATENCY edges later.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_prod holds its value. No accepted request is lost or duplicated.
- R8: After reset, out_valid is low and in_ready is high.
- R9: Known answer. First operand high 0x7b5b546573745665, low 0x63746f725d53475d. Second operand high 0x4869285368617929, low 0x5b477565726f6e5d. With control 0x00 the product is 0x1d4d84c85c3440c0_929633d5d36f0451. Squaring a low half of 0x8000000000000000 gives only bit 126 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The block can take a request this cycle |
| in_a | input | 128*LANES | First operand vector |
| in_b | input | 128*LANES | Second operand vector |
| in_ctl | input | 8 | Half-select control byte, shared by all lanes |
| out_valid | output | 1 | out_prod holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_prod | output | 128*LANES | Per-lane 128-bit products |

## Verification
A result is due LATENCY clock edges after the edge that accepted its request, provided out_ready stays high. The directed checks drive a request before an edge and count LATENCY edges. They confirm out_valid is still low one edge early and then sample out_valid and out_prod at the falling edge after the last register stage. In the random phase out_ready toggles. There the results are matched in order at each falling edge where out_valid and out_ready are both high, so any stall moves the due cycle without breaking the comparison. Every stalled cycle is also checked for a held value.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;

  localparam int unsigned HALF_W = 64;
  localparam int unsigned LANE_W = 2 * HALF_W;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [LANE_W-1:0] lane_t;

  // Carry-less product: XOR of shifted copies of x gated by the bits of y.
  function automatic lane_t clmul_half(input half_t x, input half_t y);
    lane_t acc;
    acc = '0;
    for (int i = 0; i < HALF_W; i++) begin
      if (y[i]) acc = acc ^ (lane_t'(x) << i);
    end
    return acc;
  endfunction

  // Selector helper: picks the upper or lower half of a lane.
  function automatic half_t pick_half(input lane_t v, input logic upper);
    return upper ? v[LANE_W-1:HALF_W] : v[HALF_W-1:0];
  endfunction

endpackage

// File: rtl/gf2m_lane.sv
module gf2m_lane
  import gf2m_pkg::*;
(
  input  lane_t opa,
  input  lane_t opb,
  input  logic  sel_a,
  input  logic  sel_b,
  output lane_t prod
);

  half_t ha;
  half_t hb;

  assign ha   = pick_half(opa, sel_a);
  assign hb   = pick_half(opb, sel_b);
  assign prod = clmul_half(ha, hb);

  always_comb begin
    // R1: a zero factor gives a zero product
    p_zero_factor_r1: assert ((ha != '0 && hb != '0) || prod == '0);
    // R1: lowest product bit is the AND of the lowest factor bits
    p_low_bit_r1: assert (prod[0] == (ha[0] & hb[0]));
    // R5: degree never exceeds 126
    p_no_top_bit_r5: assert (prod[LANE_W-1] == 1'b0);
  end

endmodule

// File: rtl/gf2m_pipe.sv
module gf2m_pipe #(
  parameter int unsigned W     = 512,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] stg_v;
  logic [W-1:0]     stg_d [DEPTH];
  logic [DEPTH:0]   stg_go;   // stage i may load this cycle
  logic             up_fire;

  always_comb begin
    stg_go[DEPTH] = dn_ready;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      stg_go[i] = !stg_v[i] || stg_go[i+1];
    end
  end

  assign up_ready = stg_go[0];
  assign up_fire  = up_valid && up_ready;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic         src_v;
    logic [W-1:0] src_d;
    if (s == 0) begin : g_head
      assign src_v = up_valid;
      assign src_d = up_data;
    end else begin : g_body
      assign src_v = stg_v[s-1];
      assign src_d = stg_d[s-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_v[s] <= 1'b0;
        stg_d[s] <= '0;
      end else if (stg_go[s+1] || !stg_v[s]) begin
        stg_v[s] <= src_v;
        if (src_v) stg_d[s] <= src_d;
      end
    end
  end

  assign dn_valid = stg_v[LAST];
  assign dn_data  = stg_d[LAST];

  // R6: an accepted request occupies the first stage on the next cycle
  p_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_fire |=> stg_v[0]);

  // R7: a stalled result is held, value included
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

  // R8: out of reset the pipeline is empty
  p_reset_empty_r8: assert property (@(posedge clk)
    $rose(rst_n) |-> (!dn_valid && up_ready));

endmodule

// File: rtl/gf2_lane_mul.sv
module gf2_lane_mul
  import gf2m_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter int unsigned LATENCY = 2,
  parameter int unsigned SEL_A_BIT = 0,
  parameter int unsigned SEL_B_BIT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*LANE_W-1:0] in_a,
  input  logic [LANES*LANE_W-1:0] in_b,
  input  logic [7:0]              in_ctl,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*LANE_W-1:0] out_prod
);

  localparam int unsigned VEC_W = LANES * LANE_W;

  logic             sel_a;
  logic             sel_b;
  logic [VEC_W-1:0] raw_prod;
  logic [LANES-1:0] out_top_bits;

  assign sel_a = in_ctl[SEL_A_BIT];
  assign sel_b = in_ctl[SEL_B_BIT];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    gf2m_lane u_lane (
      .opa   (in_a[l*LANE_W +: LANE_W]),
      .opb   (in_b[l*LANE_W +: LANE_W]),
      .sel_a (sel_a),
      .sel_b (sel_b),
      .prod  (raw_prod[l*LANE_W +: LANE_W])
    );
    assign out_top_bits[l] = out_prod[l*LANE_W + LANE_W - 1];
  end

  gf2m_pipe #(
    .W     (VEC_W),
    .DEPTH (LATENCY)
  ) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (raw_prod),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_prod)
  );

  // R5: no lane of a delivered result has its top bit set
  p_out_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_top_bits == '0));

  // R8: nothing is presented while idle after reset
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !out_valid) |-> (out_top_bits == '0));

endmodule

// File: tb/sim_gf2_lane_mul.sv
module sim_gf2_lane_mul;

  localparam int LANES = 4;
  localparam int LAT   = 2;
  localparam int VW    = LANES * 128;
  localparam int NRND  = 300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_a = '0;
  logic [VW-1:0] in_b = '0;
  logic [7:0]    in_ctl = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [VW-1:0] out_prod;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [VW-1:0] exp_q [NRND];

  always #5 clk = ~clk;

  gf2_lane_mul #(.LANES(LANES), .LATENCY(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_ctl(in_ctl), .out_valid(out_valid),
    .out_ready(out_ready), .out_prod(out_prod)
  );

  // Bit-serial convolution model of one lane
  function automatic logic [127:0] ref_lane(input logic [127:0] a,
                                            input logic [127:0] b,
                                            input logic [7:0] c);
    logic [63:0]  x, y;
    logic [127:0] r;
    x = c[0] ? a[127:64] : a[63:0];
    y = c[4] ? b[127:64] : b[63:0];
    r = '0;
    for (int k = 0; k < 127; k++) begin
      logic bitv;
      bitv = 1'b0;
      for (int i = 0; i < 64; i++) begin
        if (k - i >= 0 && k - i < 64) bitv = bitv ^ (x[i] & y[k-i]);
      end
      r[k] = bitv;
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] ref_vec(input logic [VW-1:0] a,
                                           input logic [VW-1:0] b,
                                           input logic [7:0] c);
    logic [VW-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l*128 +: 128] = ref_lane(a[l*128 +: 128], b[l*128 +: 128], c);
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int w = 0; w < VW / 32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [VW-1:0] act, input logic [VW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Directed request with out_ready high; checks latency and value
  task automatic run_one(input logic [VW-1:0] a, input logic [VW-1:0] b,
                         input logic [7:0] c, input string req,
                         output logic [VW-1:0] got);
    logic [VW-1:0] e;
    e = ref_vec(a, b, c);
    @(negedge clk);
    out_ready = 1'b1;
    in_a = a; in_b = b; in_ctl = c; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT - 1) begin
      // R6: not due yet
      check(!out_valid, "R6 early", VW'(out_valid), '0);
      @(negedge clk);
    end
    check(out_valid, "R6 due", VW'(out_valid), VW'(1));
    check(out_prod == e, req, out_prod, e);
    got = out_prod;
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a, b, g1, g2, kat_a, kat_b, e;
    void'($urandom(32'd20417));

    repeat (3) @(negedge clk);
    // R8: reset state
    check(!out_valid && in_ready, "R8 reset", VW'({out_valid, in_ready}), VW'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R8 after", VW'({out_valid, in_ready}), VW'(1));

    // R9: known answer broadcast to every lane
    for (int l = 0; l < LANES; l++) begin
      kat_a[l*128 +: 128] = {64'h7b5b546573745665, 64'h63746f725d53475d};
      kat_b[l*128 +: 128] = {64'h4869285368617929, 64'h5b477565726f6e5d};
      e[l*128 +: 128]     = {64'h1d4d84c85c3440c0, 64'h929633d5d36f0451};
    end
    run_one(kat_a, kat_b, 8'h00, "R9 kat model", g1);
    check(g1 == e, "R9 kat constant", g1, e);

    // R2: all four half choices on the known operands
    run_one(kat_a, kat_b, 8'h01, "R2 sel 01", g1);
    run_one(kat_a, kat_b, 8'h10, "R2 sel 10", g1);
    run_one(kat_a, kat_b, 8'h11, "R2 sel 11", g1);

    // R9/R5: bit 63 squared gives only bit 126
    for (int l = 0; l < LANES; l++) begin
      a[l*128 +: 128] = {64'h0, 64'h8000000000000000};
      e[l*128 +: 128] = {64'h4000000000000000, 64'h0};
    end
    run_one(a, a, 8'h00, "R9 corner model", g1);
    check(g1 == e, "R9 corner constant", g1, e);
    for (int l = 0; l < LANES; l++)
      check(g1[l*128+127] == 1'b0, "R5 top bit", VW'(g1[l*128+127]), '0);

    // R3: unused control bits do nothing
    a = rnd_vec(); b = rnd_vec();
    run_one(a, b, 8'h00, "R1 base", g1);
    run_one(a, b, 8'hEE, "R3 ctl EE", g2);
    check(g1 == g2, "R3 EE vs 00", g2, g1);
    run_one(a, b, 8'h11, "R1 base hi", g1);
    run_one(a, b, 8'hFF, "R3 ctl FF", g2);
    check(g1 == g2, "R3 FF vs 11", g2, g1);

    // R4: changing one lane's operands moves only that lane
    run_one(a, b, 8'h10, "R4 ref", g1);
    b[2*128 +: 128] = ~b[2*128 +: 128];
    run_one(a, b, 8'h10, "R4 lane2 flip", g2);
    for (int l = 0; l < LANES; l++)
      if (l != 2)
        check(g1[l*128 +: 128] == g2[l*128 +: 128], "R4 other lane",
              g2, g1);

    // R7: stall holds value
    a = rnd_vec(); b = rnd_vec();
    e = ref_vec(a, b, 8'h01);
    @(negedge clk);
    out_ready = 1'b0;
    in_a = a; in_b = b; in_ctl = 8'h01; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    check(out_valid && out_prod == e, "R7 stalled", out_prod, e);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R7 no dup", VW'(out_valid), '0);

    // Random phase with back-pressure (R1, R2, R4, R7)
    fork
      begin : drv
        for (int k = 0; k < NRND; k++) begin
          logic [VW-1:0] ra, rb;
          logic [7:0]    rc;
          ra = rnd_vec(); rb = rnd_vec(); rc = 8'($urandom);
          if (k % 17 == 0) ra = '0;
          exp_q[k] = ref_vec(ra, rb, rc);
          @(negedge clk);
          in_a = ra; in_b = rb; in_ctl = rc; in_valid = 1'b1;
          #1;
          while (!in_ready) begin @(negedge clk); #1; end
          @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin : rdy
        while (!done) begin
          @(posedge clk);
          #1 out_ready = ($urandom % 4) != 0;
        end
        out_ready = 1'b1;
      end
      begin : mon
        int rd;
        bit was_stall;
        logic [VW-1:0] held;
        rd = 0;
        was_stall = 0;
        held = '0;
        while (rd < NRND) begin
          @(negedge clk);
          #1;
          if (was_stall)
            check(out_valid && out_prod == held, "R7 random hold", out_prod, held);
          was_stall = out_valid && !out_ready;
          held = out_prod;
          if (out_valid && out_ready) begin
            check(out_prod == exp_q[rd], "R1 random", out_prod, exp_q[rd]);
            rd++;
          end
        end
        done = 1;
      end
    join

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule